// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the serial master side of the MII management link. A client presents one request (read or write, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data) together with a one-cycle start strobe. The block then produces the management clock from the system clock through a parameterised prescaler. It drives the data line and its output enable through the whole frame, and it hands the line over to the PHY when a read needs it.

Each frame opens with a synchronisation preamble and then carries the start delimiter, the opcode and the two address fields. On a write it sends the turnaround pattern, the data and a closing idle clock. On a read it sends one idle bit, releases the line and samples an acknowledge, then shifts in 16 data bits and adds one trailing clock. If the PHY does not acknowledge, the data clocks are still issued so that every PHY on the shared line stays in step. The result is then an error flag and not data. Completion is marked by a single-cycle done pulse, and busy covers the whole transaction.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no transaction is running, busy, done, mdc and mdio_oe are low.
- R2: Every frame begins with PRE_LEN (default 32) MDC cycles in which mdio_oe is high and mdio_o is high.
- R3: After the preamble the block drives 14 bits MSB first: start delimiter 01, opcode (10 for a read, 01 for a write), the 5-bit PHY address, then the 5-bit register address.
- R4: On a write, the header is followed by the turnaround pattern 10, then 16 data bits MSB first, then one idle MDC cycle with mdio_oe high and mdio_o low. The output is released after that cycle.
- R5: On a read, the header is followed by one idle MDC cycle with mdio_oe high and mdio_o low. mdio_oe is low for the remaining 18 MDC cycles.
- R6: On a read, mdio_i is sampled just before the MDC rising edge. A low value in the first released cycle is the acknowledge. The next 16 cycles form rd_data MSB first, and rd_nack is 0.
- R7: If the acknowledge bit is high, the frame still runs its 16 data cycles and its trailing cycle. At done, rd_nack is 1 and rd_data is 0.
- R8: MDC is low and then high for HALF_DIV system clocks each (default 4). Every frame, read or write, lasts PRE_LEN+33 MDC cycles. mdio_o and mdio_oe change only while MDC is low.
- R9: busy rises in the cycle after an accepted start and stays high for exactly (PRE_LEN+33)*2*HALF_DIV cycles. done is a one-cycle pulse in the cycle busy falls. After a write, rd_nack is 0.
- R10: A start strobe while busy is high is ignored. The running frame is unchanged, and no second transaction follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid at done |
| rd_nack | output | 1 | Read not acknowledged, valid at done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A wrong bit index or a skipped shift moves a header, turnaround or data bit into the wrong MDC cycle. That shows up on mdio_o at the first misplaced rising edge, well before done. A wrong direction switch makes mdio_oe disagree with the read or write frame layout at cycle PRE_LEN+15. An off-by-one in the capture window or in the acknowledge index corrupts rd_data or rd_nack, which is visible at the done pulse. A prescaler or frame-length error changes the MDC high time or the busy length on the very first transaction.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int PHY_W    = 5;
   localparam int REG_W    = 5;
   localparam int DATA_W   = 16;
   localparam int HDR_BITS = 2 + 2 + PHY_W + REG_W;   // delimiter, opcode, two addresses
   localparam int TAIL_BITS = HDR_BITS + 2 + DATA_W + 1; // header, turn, data, closing cycle
   localparam int SH_W     = HDR_BITS + 2 + DATA_W;

   localparam logic [1:0] FRM_START = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] TURN_WR   = 2'b10;

   typedef struct packed {
      logic              wr;
      logic [PHY_W-1:0]  phy;
      logic [REG_W-1:0]  regad;
      logic [DATA_W-1:0] wdata;
   } mdio_req_t;
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc_lvl,
   output logic rise_now,
   output logic bit_end
);
   localparam int PERIOD = 2 * HALF_DIV;
   localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

   logic [CW-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            phase <= '0;
      else if (!run)                         phase <= '0;
      else if (phase == CW'(PERIOD - 1))     phase <= '0;
      else                                   phase <= phase + 1'b1;
   end

   // low half first, high half second
   assign mdc_lvl  = run && (phase >= CW'(HALF_DIV));
   assign rise_now = run && (phase == CW'(HALF_DIV - 1));
   assign bit_end  = run && (phase == CW'(PERIOD - 1));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int KW      = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  mdio_req_t       req,
   input  logic            bit_end,
   output logic            busy,
   output logic            done,
   output logic            accept,
   output logic            fin,
   output logic            wr_q,
   output logic [KW-1:0]   idx,
   output logic            mdo_n,
   output logic            oe_n
);
   localparam int LAST     = PRE_LEN + TAIL_BITS - 1;
   localparam int DRIVE_RD = PRE_LEN + HDR_BITS + 1;   // read keeps the line up to here

   logic [SH_W-1:0] sh;
   logic [SH_W-1:0] load_v;

   always_comb begin
      if (req.wr) load_v = {FRM_START, OPC_WRITE, req.phy, req.regad, TURN_WR, req.wdata};
      else        load_v = {FRM_START, OPC_READ,  req.phy, req.regad, {(2 + DATA_W){1'b0}}};
   end

   assign accept = start && !busy;
   assign fin    = busy && bit_end && (idx == KW'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         wr_q <= 1'b0;
         idx  <= '0;
         sh   <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy <= 1'b1;
            wr_q <= req.wr;
            idx  <= '0;
            sh   <= load_v;
         end else if (busy && bit_end) begin
            if (fin) begin
               busy <= 1'b0;
               done <= 1'b1;
               idx  <= '0;
            end else begin
               idx <= idx + 1'b1;
            end
            if (idx >= KW'(PRE_LEN)) sh <= {sh[SH_W-2:0], 1'b0};
         end
      end
   end

   assign mdo_n = !busy || (idx < KW'(PRE_LEN)) || sh[SH_W-1];
   assign oe_n  = busy && (wr_q || (idx < KW'(DRIVE_RD)));
endmodule

// File: rtl/mdio_rx.sv
module mdio_rx
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int KW      = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              fin,
   input  logic              rise_now,
   input  logic              wr_q,
   input  logic [KW-1:0]     idx,
   input  logic              mdio_i,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_nack
);
   localparam int ACK_IDX = PRE_LEN + HDR_BITS + 1;
   localparam int D_LO    = ACK_IDX + 1;
   localparam int D_HI    = ACK_IDX + DATA_W;

   logic [DATA_W-1:0] cap;
   logic              no_ack;
   logic              in_data;

   assign in_data = (idx >= KW'(D_LO)) && (idx <= KW'(D_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap    <= '0;
         no_ack <= 1'b0;
      end else if (accept) begin
         cap    <= '0;
         no_ack <= 1'b0;
      end else if (rise_now && !wr_q) begin
         if (idx == KW'(ACK_IDX))     no_ack <= mdio_i;
         else if (in_data && !no_ack) cap    <= {cap[DATA_W-2:0], mdio_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_nack <= 1'b0;
      end else if (fin) begin
         rd_data <= (wr_q || no_ack) ? '0 : cap;
         rd_nack <= !wr_q && no_ack;
      end
   end
endmodule

// File: rtl/mdio_pins.sv
module mdio_pins #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc_n,
   input  logic mdo_n,
   input  logic oe_n,
   output logic mdc,
   output logic mdio_o,
   output logic mdio_oe
);
   generate
      if (REG_OUT) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mdc     <= 1'b0;
               mdio_o  <= 1'b1;
               mdio_oe <= 1'b0;
            end else begin
               mdc     <= mdc_n;
               mdio_o  <= mdo_n;
               mdio_oe <= oe_n;
            end
         end
      end else begin : g_wire
         assign mdc     = mdc_n;
         assign mdio_o  = mdo_n;
         assign mdio_oe = oe_n;
      end
   endgenerate
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int HALF_DIV = 4,
   parameter int PRE_LEN  = 32,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              req_wr,
   input  logic [PHY_W-1:0]  req_phy,
   input  logic [REG_W-1:0]  req_reg,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_nack,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   localparam int FRAME = PRE_LEN + TAIL_BITS;
   localparam int KW    = $clog2(FRAME + 1);

   generate
      if (HALF_DIV < 2) begin : g_bad_div
         $error("HALF_DIV must be at least 2");
      end
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
         $error("PRE_LEN must lie in 1..64");
      end
   endgenerate

   mdio_req_t       req;
   logic            mdc_lvl, rise_now, bit_end;
   logic            accept, fin, wr_q, mdo_n, oe_n;
   logic [KW-1:0]   idx;

   assign req = '{wr: req_wr, phy: req_phy, regad: req_reg, wdata: req_wdata};

   mdio_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy),
      .mdc_lvl(mdc_lvl), .rise_now(rise_now), .bit_end(bit_end)
   );

   mdio_seq #(.PRE_LEN(PRE_LEN), .KW(KW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .req(req), .bit_end(bit_end),
      .busy(busy), .done(done), .accept(accept), .fin(fin), .wr_q(wr_q),
      .idx(idx), .mdo_n(mdo_n), .oe_n(oe_n)
   );

   mdio_rx #(.PRE_LEN(PRE_LEN), .KW(KW)) u_rx (
      .clk(clk), .rst_n(rst_n), .accept(accept), .fin(fin), .rise_now(rise_now),
      .wr_q(wr_q), .idx(idx), .mdio_i(mdio_i), .rd_data(rd_data), .rd_nack(rd_nack)
   );

   mdio_pins #(.REG_OUT(REG_OUT)) u_pins (
      .clk(clk), .rst_n(rst_n), .mdc_n(mdc_lvl), .mdo_n(mdo_n), .oe_n(oe_n),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int HALF_DIV = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic [15:0] rd_data,
   input logic        rd_nack,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe
);
   logic [15:0] hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hi_len <= '0;
      else if (mdc) hi_len <= hi_len + 1'b1;
      else          hi_len <= '0;
   end

   // R8: each MDC high phase lasts HALF_DIV system clocks
   assert_mdc_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc) |-> hi_len == 16'(HALF_DIV));

   // R8: line value and direction hold while MDC is high
   assert_hold_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R9: done only as busy drops
   assert_done_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R10: busy only rises in answer to a start strobe
   assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R7: a refused read returns no data
   assert_nack_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rd_nack) |-> rd_data == 16'h0000);

   // R1: no clock and no drive without a transaction
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> (!mdc && !mdio_oe));
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .rd_data(rd_data), .rd_nack(rd_nack), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
   localparam int HALF  = 4;
   localparam int FRAME = 65;
   localparam int ACK   = 47;

   typedef struct packed {
      logic        w;
      logic [4:0]  p;
      logic [4:0]  r;
      logic [15:0] d;
      logic [15:0] rsp;
      logic        ab;
   } vec_t;

   localparam vec_t VEC [0:5] = '{
      '{1'b1, 5'h01, 5'h00, 16'hA5C3, 16'h0000, 1'b0},
      '{1'b0, 5'h1F, 5'h1F, 16'h0000, 16'h1234, 1'b0},
      '{1'b1, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, 1'b0},
      '{1'b0, 5'h00, 5'h01, 16'h0000, 16'h8001, 1'b1},
      '{1'b1, 5'h10, 5'h0A, 16'h0000, 16'h0000, 1'b0},
      '{1'b0, 5'h05, 5'h11, 16'h0000, 16'hFFFF, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, req_wr = 1'b0, mdio_i = 1'b1;
   logic [4:0]  req_phy = '0, req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic busy, done, rd_nack, mdc, mdio_o, mdio_oe;
   logic [15:0] rd_data;

   int checks = 0, errors = 0;
   int rc = 0;
   logic log_o [0:79];
   logic log_oe [0:79];
   logic [15:0] cur_rsp = '0;
   logic        cur_ab = 1'b0;

   always #2 clk = ~clk;

   mdio_master dut (
      .clk(clk), .rst_n(rst_n), .start(start), .req_wr(req_wr), .req_phy(req_phy),
      .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
      .rd_data(rd_data), .rd_nack(rd_nack), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model: records each rising edge, drives the value for the next cycle
   always @(posedge mdc) begin
      #1;
      if (rc < 80) begin
         log_o[rc]  = mdio_o;
         log_oe[rc] = mdio_oe;
      end
      if (rc + 1 == ACK)                     mdio_i = cur_ab;
      else if (rc + 1 >= 48 && rc + 1 <= 63) mdio_i = cur_rsp[63 - (rc + 1)];
      else                                   mdio_i = 1'b1;
      rc = rc + 1;
   end

   task automatic chk(input logic ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic exp_o(input int k, input logic w, input logic [4:0] p,
                                  input logic [4:0] r, input logic [15:0] d);
      logic [31:0] v;
      v = w ? {2'b01, 2'b01, p, r, 2'b10, d} : {2'b01, 2'b10, p, r, 18'b0};
      if (k < 32) return 1'b1;
      if (k < 64) return v[63 - k];
      return 1'b0;
   endfunction

   function automatic logic exp_oe(input int k, input logic w);
      return w || (k <= 46);
   endfunction

   // poke > 0: issue a conflicting start that many cycles into the frame
   task automatic run_txn(input vec_t v, input int poke);
      int blen, bad_pre, bad_hdr, bad_tail;
      logic got_done, after_done, lingering;
      logic [15:0] got_rd;
      logic got_nk;
      cur_rsp = v.rsp;
      cur_ab  = v.ab;
      rc      = 0;
      mdio_i  = 1'b1;
      @(negedge clk);
      start = 1'b1; req_wr = v.w; req_phy = v.p; req_reg = v.r; req_wdata = v.d;
      @(negedge clk);
      start = 1'b0;
      blen = 0;
      while (busy && blen < 5000) begin
         blen++;
         @(negedge clk);
         if (poke > 0 && blen == poke) begin
            start = 1'b1; req_wr = ~v.w; req_phy = ~v.p; req_reg = ~v.r; req_wdata = ~v.d;
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      got_done = done; got_rd = rd_data; got_nk = rd_nack;
      @(negedge clk);
      after_done = done;
      repeat (3) @(negedge clk);
      lingering = busy;
      bad_pre = 0; bad_hdr = 0; bad_tail = 0;
      for (int k = 0; k < FRAME; k++) begin
         if (log_oe[k] !== exp_oe(k, v.w) ||
             (exp_oe(k, v.w) && log_o[k] !== exp_o(k, v.w, v.p, v.r, v.d))) begin
            if (k < 32) bad_pre++; else if (k < 46) bad_hdr++; else bad_tail++;
         end
      end
      chk(bad_pre == 0, "R2", "preamble mismatches", bad_pre, 0);
      chk(bad_hdr == 0, "R3", "header mismatches", bad_hdr, 0);
      chk(bad_tail == 0, v.w ? "R4" : "R5", "tail mismatches", bad_tail, 0);
      chk(rc == FRAME, "R8", "mdc rising edges", rc, FRAME);
      chk(blen == FRAME * 2 * HALF, "R9", "busy length", blen, FRAME * 2 * HALF);
      chk(got_done && !after_done, "R9", "done pulse shape", {got_done, after_done}, 2);
      if (v.w) begin
         chk(got_nk == 1'b0, "R9", "nack after write", got_nk, 0);
      end else if (v.ab) begin
         chk(got_nk == 1'b1 && got_rd == 16'h0, "R7", "nack/rdata", {got_nk, got_rd}, 32'h10000);
      end else begin
         chk(got_nk == 1'b0 && got_rd == v.rsp, "R6", "nack/rdata", {got_nk, got_rd}, {1'b0, v.rsp});
      end
      if (poke > 0)
         chk(!lingering, "R10", "busy after ignored start", lingering, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !mdc && !mdio_oe, "R1", "idle outputs",
          {busy, done, mdc, mdio_oe}, 0);

      // table walk: R2..R9
      for (int i = 0; i < 6; i++) run_txn(VEC[i], 0);

      // R10: conflicting starts during a read and during a write
      run_txn(VEC[1], 100);
      run_txn(VEC[0], 300);

      // R1: reset in the middle of a frame returns the pins to idle
      @(negedge clk);
      start = 1'b1; req_wr = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (60) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !mdc && !mdio_oe, "R1", "idle after mid-frame reset",
          {busy, mdc, mdio_oe}, 0);

      // back-to-back after reset
      run_txn(VEC[5], 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule